// File: doc/BRIEF.md
# Timeslot PRBS Error Checker

This block checks test traffic carried in the receive timeslots of a 24-slot frame. For each byte strobe, it checks the timeslot index against a per-slot enable mask. Bytes from enabled slots form one continuous bit stream, taken in the order they arrive. The checker compares this stream with a 2^15-1 pseudo-random sequence, that is, the sequence of the polynomial x^15 + x^14 + 1.

The reference is rebuilt from the received bits themselves, so the checker locks with no seed and no handshake. Errors counted just after start-up are normal and should be cleared. Mismatched bits go into a saturating 8-bit counter. If the counter would wrap, a sticky overflow flag is set. An interrupt line follows the flag unless the mask input is set. Checking runs only while the mode select input is low.

Top module: `prbs_slot_checker`

## Requirements
- R1: After a synchronous reset, `err_count` is 0 and `ovf_flag` and `irq` are low.
- R2: A byte is checked only when `byte_valid` is high, `slot_idx` is below 24 and bit `slot_idx` of `slot_check_en` is set. Any other byte leaves the counter, the flag and the sequence tracker unchanged. Slot indices 24 to 31 are never checked.
- R3: While `mode_sel` is 1, no byte is checked. The counter, the flag and the tracker stay as they were.
- R4: Bits are taken MSB first (bit 7 first). The expected value of each bit is the XOR of the accepted bits 15 and 14 positions earlier. This history runs continuously across bytes and across different slots.
- R5: The number of mismatched bits in a checked byte (0 to 8) is added to `err_count`. The new value is visible after the clock edge that samples the strobe.
- R6: After 15 correct bits have been received, a clean sequence adds no further errors.
- R7: If a sum would exceed 255, `err_count` holds at 255 and `ovf_flag` is set.
- R8: `ovf_flag` stays set until `cnt_clear` is pulsed. `cnt_clear` zeroes the counter and the flag. A byte checked in the same cycle is absorbed by the tracker, but its errors are dropped.
- R9: `irq` is high exactly when `ovf_flag` is 1 and `irq_mask` is 0.
- R10: Once the checker is locked, a single inverted bit in the stream produces exactly 3 counted errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte, bit 7 first on the line |
| slot_idx | input | 5 | Timeslot index of `rx_byte` |
| byte_valid | input | 1 | Byte strobe |
| slot_check_en | input | 24 | Per-slot check enable, bit n for slot n |
| mode_sel | input | 1 | 0 = checking active, 1 = checking off |
| cnt_clear | input | 1 | Clears counter and overflow flag |
| irq_mask | input | 1 | 1 suppresses `irq` |
| err_count | output | 8 | Saturating bit-error count |
| ovf_flag | output | 1 | Sticky overflow status |
| irq | output | 1 | Masked overflow interrupt |

## Verification
A clean generated sequence, spread over randomly chosen enabled slots, shows whether the tracker locks and stays quiet. It also shows whether the slot order is handled as a single stream. Garbage bytes on disabled slots, on indices above 23 and while `mode_sel` is high are followed by clean data. A later error there would show that the tracker was disturbed. A single flipped bit separates the correct two-tap feedback from wrong taps or a wrong bit order. Random corrupt bytes drive the counter into saturation, which exercises the flag, the mask and the clear priority.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int NUM_SLOTS = 24;
    localparam int SLOT_W    = 5;
    localparam int BYTE_W    = 8;
    localparam int PRBS_LEN  = 15;
    localparam int CNT_W     = 8;
    localparam int MISS_W    = $clog2(BYTE_W + 1);

    typedef logic [PRBS_LEN-1:0] prbs_state_t;

    typedef struct packed {
        prbs_state_t       nxt_state;
        logic [MISS_W-1:0] miss;
    } byte_check_t;

    // Walk one byte MSB first through the self-synchronising reference.
    function automatic byte_check_t check_byte(prbs_state_t st, logic [BYTE_W-1:0] din);
        byte_check_t res;
        logic        expct;
        res.nxt_state = st;
        res.miss      = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            expct = res.nxt_state[PRBS_LEN-1] ^ res.nxt_state[PRBS_LEN-2];
            res.miss = res.miss + MISS_W'(expct ^ din[i]);
            res.nxt_state = {res.nxt_state[PRBS_LEN-2:0], din[i]};
        end
        return res;
    endfunction

endpackage

// File: rtl/prbs_slot_gate.sv
module prbs_slot_gate
    import prbs_chk_pkg::*;
#(
    parameter int N_SLOTS = NUM_SLOTS,
    parameter int S_W     = SLOT_W
) (
    input  logic [S_W-1:0]     slot_idx,
    input  logic               byte_valid,
    input  logic               mode_sel,
    input  logic [N_SLOTS-1:0] slot_check_en,
    output logic               take
);
    logic [N_SLOTS-1:0] hit;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign hit[g] = slot_check_en[g] && (slot_idx == S_W'(g));
    end

    assign take = byte_valid && !mode_sel && (|hit);
endmodule

// File: rtl/prbs_tracker.sv
module prbs_tracker
    import prbs_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [MISS_W-1:0] miss
);
    prbs_state_t state_q;
    byte_check_t res;

    always_comb res = check_byte(state_q, rx_byte);

    assign miss = take ? res.miss : '0;

    always_ff @(posedge clk) begin
        if (rst)       state_q <= '0;
        else if (take) state_q <= res.nxt_state;
    end
endmodule

// File: rtl/prbs_err_accum.sv
module prbs_err_accum
    import prbs_chk_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clear,
    input  logic              irq_mask,
    input  logic [MISS_W-1:0] miss,
    output logic [C_W-1:0]    err_count,
    output logic              ovf_flag,
    output logic              irq
);
    localparam logic [C_W:0] CNT_MAX = {1'b0, {C_W{1'b1}}};

    logic [C_W:0] sum;

    assign sum = {1'b0, err_count} + (C_W+1)'(miss);

    always_ff @(posedge clk) begin
        if (rst || cnt_clear) begin
            err_count <= '0;
            ovf_flag  <= 1'b0;
        end else if (sum > CNT_MAX) begin
            err_count <= '1;
            ovf_flag  <= 1'b1;
        end else begin
            err_count <= sum[C_W-1:0];
        end
    end

    assign irq = ovf_flag & ~irq_mask;
endmodule

// File: rtl/prbs_slot_checker.sv
module prbs_slot_checker
    import prbs_chk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic                 byte_valid,
    input  logic [NUM_SLOTS-1:0] slot_check_en,
    input  logic                 mode_sel,
    input  logic                 cnt_clear,
    input  logic                 irq_mask,
    output logic [CNT_W-1:0]     err_count,
    output logic                 ovf_flag,
    output logic                 irq
);
    logic              take;
    logic [MISS_W-1:0] miss;

    prbs_slot_gate #(.N_SLOTS(NUM_SLOTS), .S_W(SLOT_W)) u_gate (
        .slot_idx      (slot_idx),
        .byte_valid    (byte_valid),
        .mode_sel      (mode_sel),
        .slot_check_en (slot_check_en),
        .take          (take)
    );

    prbs_tracker u_trk (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .rx_byte (rx_byte),
        .miss    (miss)
    );

    prbs_err_accum #(.C_W(CNT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .cnt_clear (cnt_clear),
        .irq_mask  (irq_mask),
        .miss      (miss),
        .err_count (err_count),
        .ovf_flag  (ovf_flag),
        .irq       (irq)
    );
endmodule

// File: rtl/prbs_slot_checker_sva.sv
module prbs_slot_checker_sva
    import prbs_chk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             byte_valid,
    input logic             mode_sel,
    input logic             cnt_clear,
    input logic             irq_mask,
    input logic [CNT_W-1:0] err_count,
    input logic             ovf_flag,
    input logic             irq
);
    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (err_count == '0) && !ovf_flag);

    a_r2_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid && !cnt_clear) |=> $stable(err_count) && $stable(ovf_flag));

    a_r3_mode_off_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && !cnt_clear) |=> $stable(err_count) && $stable(ovf_flag));

    a_r5_step_bound: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !cnt_clear) |=> (err_count >= $past(err_count)) &&
                                      ((err_count - $past(err_count)) <= CNT_W'(BYTE_W)));

    a_r7_sat_on_ovf: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (err_count == '1));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !cnt_clear) |=> ovf_flag);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        cnt_clear |=> (err_count == '0) && !ovf_flag);

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_flag && !irq_mask));
endmodule

bind prbs_slot_checker prbs_slot_checker_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .mode_sel   (mode_sel),
    .cnt_clear  (cnt_clear),
    .irq_mask   (irq_mask),
    .err_count  (err_count),
    .ovf_flag   (ovf_flag),
    .irq        (irq)
);

// File: tb/sim_prbs_slot_checker.sv
`timescale 1ns/1ps
module sim_prbs_slot_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  rx_byte;
    logic [4:0]  slot_idx;
    logic        byte_valid;
    logic [23:0] slot_check_en;
    logic        mode_sel;
    logic        cnt_clear;
    logic        irq_mask;
    logic [7:0]  err_count;
    logic        ovf_flag;
    logic        irq;

    always #4 clk = ~clk;

    prbs_slot_checker u0 (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .slot_idx(slot_idx),
        .byte_valid(byte_valid), .slot_check_en(slot_check_en),
        .mode_sel(mode_sel), .cnt_clear(cnt_clear), .irq_mask(irq_mask),
        .err_count(err_count), .ovf_flag(ovf_flag), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference: history of accepted bits, hist[0] newest.
    logic [14:0] hist;
    int          m_cnt;
    bit          m_ovf;
    // Clean sequence source.
    logic [14:0] gen;

    function automatic logic [7:0] gen_byte();
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            b[i] = gen[14] ^ gen[13];
            gen  = {gen[13:0], b[i]};
        end
        return b;
    endfunction

    function automatic int model_byte(logic [7:0] b);
        int e = 0;
        for (int i = 7; i >= 0; i--) begin
            if ((hist[14] ^ hist[13]) != b[i]) e++;
            hist = {hist[13:0], b[i]};
        end
        return e;
    endfunction

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_state(string req);
        check({req, " count"}, int'(err_count), m_cnt);
        check({req, " ovf"},   int'(ovf_flag),  int'(m_ovf));
        check({req, " irq"},   int'(irq),       int'(m_ovf && !irq_mask));
    endtask

    task automatic send(logic [7:0] b, logic [4:0] s, bit v, bit clr);
        bit accepted;
        int e;
        @(negedge clk);
        rx_byte = b; slot_idx = s; byte_valid = v; cnt_clear = clr;
        @(posedge clk);
        @(negedge clk);
        byte_valid = 0; cnt_clear = 0;
        accepted = v && !mode_sel && (s < 24) && slot_check_en[s];
        e = accepted ? model_byte(b) : 0;
        if (clr) begin
            m_cnt = 0; m_ovf = 0;
        end else if (m_cnt + e > 255) begin
            m_cnt = 255; m_ovf = 1;
        end else begin
            m_cnt = m_cnt + e;
        end
    endtask

    task automatic lock_and_clear();
        for (int i = 0; i < 3; i++) send(gen_byte(), 5'd0, 1, 0);
        send(8'h00, 5'd0, 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R5: watchdog expired, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        hist = '0; m_cnt = 0; m_ovf = 0; gen = 15'h1ACE;
        rst = 1; rx_byte = 0; slot_idx = 0; byte_valid = 0;
        slot_check_en = 24'h000001; mode_sel = 0; cnt_clear = 0; irq_mask = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        check_state("R1");

        // R4/R6: lock on clean data, then clean bytes add nothing.
        lock_and_clear();
        for (int i = 0; i < 20; i++) begin
            send(gen_byte(), 5'd0, 1, 0);
            check_state("R6");
        end
        check("R6 zero after lock", int'(err_count), 0);

        // R2: disabled slots and indices above 23 are ignored.
        slot_check_en = 24'h000005;
        send(8'hA5, 5'd1, 1, 0);  check_state("R2 disabled slot");
        send(8'h3C, 5'd24, 1, 0); check_state("R2 slot 24");
        send(8'hFF, 5'd31, 1, 0); check_state("R2 slot 31");
        send(8'h5A, 5'd0, 0, 0);  check_state("R2 no strobe");
        send(gen_byte(), 5'd2, 1, 0); check_state("R2 tracker intact");

        // R3: mode select high disables.
        mode_sel = 1;
        send(8'h81, 5'd0, 1, 0); check_state("R3 off");
        mode_sel = 0;
        send(gen_byte(), 5'd0, 1, 0); check_state("R3 tracker intact");

        // R10: single inverted bit gives 3 errors; R4 continuous across slots.
        send(gen_byte() ^ 8'h10, 5'd2, 1, 0);
        for (int i = 0; i < 3; i++) send(gen_byte(), (i % 2) ? 5'd0 : 5'd2, 1, 0);
        check("R10 single flip", int'(err_count), 3);
        check_state("R4 model");

        // R5/R2: random masks, slots, corruption.
        send(8'h00, 5'd0, 0, 1);
        for (int i = 0; i < 300; i++) begin
            logic [7:0] b;
            slot_check_en = $urandom();
            b = gen_byte();
            if ($urandom_range(0, 7) == 0) b = b ^ 8'($urandom());
            mode_sel = ($urandom_range(0, 9) == 0);
            send(b, 5'($urandom()), ($urandom_range(0, 4) != 0), 0);
            check_state("R5 random");
        end
        mode_sel = 0;

        // R7/R9: garbage saturates the counter.
        slot_check_en = 24'hFFFFFF;
        for (int i = 0; i < 150; i++) begin
            send(8'($urandom()), 5'($urandom_range(0, 23)), 1, 0);
            check_state("R7 saturate");
        end
        check("R7 at max", int'(err_count), 255);
        check("R7 flag", int'(ovf_flag), 1);
        irq_mask = 1; #1;
        check("R9 masked", int'(irq), 0);
        irq_mask = 0; #1;
        check("R9 unmasked", int'(irq), 1);

        // R8: sticky, clear wins over a same-cycle byte.
        send(gen_byte(), 5'd3, 1, 0); check_state("R8 sticky");
        send(8'hF0, 5'd3, 1, 1);      check_state("R8 clear priority");
        check("R8 cleared", int'(err_count), 0);
        send(8'h0F, 5'd4, 1, 0);      check_state("R8 after clear");

        // R1: reset mid-run.
        @(negedge clk) rst = 1;
        @(posedge clk);
        @(negedge clk) rst = 0;
        hist = '0; m_cnt = 0; m_ovf = 0;
        check_state("R1 re-reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule